// File: doc/BRIEF.md
# PWM Timer with Shared Compare/Capture Register

This block is a 16-bit up-counting timer peripheral. One 16-bit value register does two jobs. In PWM mode it holds the compare point that flips the PWM level once per period. In the capture modes it is overwritten with the running count whenever the capture pin rises. A byte-wide register port gives access to the two halves of that value and to two control bytes. The counter advances only on cycles where the timer clock enable is high.

The PWM level drives a primary output and a complementary output. A small state machine separates the two. Each output turns on only after a programmable gap, counted in timer-clock cycles, has passed since the other output turned off.

A one-cycle interrupt pulse marks each reload, each capture, and each compare match in capture/compare mode. A read-only status bit tells software whether the latest pulse came from a capture. The count period is fixed by the `RELOAD_AT` parameter: the count runs 1, 2, …, `RELOAD_AT`, then returns to 1.

Register map (`reg_addr`):

- 0: value high byte. A write is staged; a read returns the live value.
- 1: value low byte. A write commits `{staged high, written low}`.
- 2: control 0. Bit 7 = mode bit 3; bits 6:4 reserved; bits 3:1 = gap select `d`; bit 0 = capture status, read-only.
- 3: control 1. Bit 7 = run enable; bit 6 = polarity; bits 5:3 reserved; bits 2:0 = mode bits 2:0.

Modes use the 4-bit code `{control0[7], control1[2:0]}`:

- `0011`: PWM.
- `0100`: capture.
- `1000`: capture/compare.
- Any other code: plain counting.

Deadband state machine:

- States: CMP_ON (complement driven), GAP_RISE (both low, waiting to drive primary), PRI_ON (primary driven), GAP_FALL (both low, waiting to drive complement).
- When the PWM level rises, CMP_ON goes to GAP_RISE. If `d`=0 it goes straight to PRI_ON.
- When the PWM level falls, PRI_ON goes to GAP_FALL. If `d`=0 it goes straight to CMP_ON.
- A gap state moves to its ON state when its gap counter expires.
- If the level reverses while in a gap state, the machine crosses to the opposite gap state and reloads the counter. If `d`=0 it crosses to the opposite ON state instead.

Top module: `pwm_capture_timer`

## Requirements
- R1: After reset, all four registers read 0x00, `pwm_out` is 0, `pwm_out_n` is 1 and `irq` is 0.
- R2: While run enable (control 1 bit 7) is set, each cycle with `tick_en` high advances the count by one. A tick at `RELOAD_AT` returns the count to 1 and raises `irq` for one cycle in the next cycle, with the status bit (control 0 bit 0) reading 0.
- R3: A write to address 0 leaves the value readable at addresses 0 and 1 unchanged. The following write to address 1 makes the value `{staged byte, written byte}` in one step.
- R4: In mode `0011` the PWM level is 0 from a reload until the count equals the value register, and 1 afterwards. Polarity (control 1 bit 6) set to 1 inverts it. With gap 0, `pwm_out` follows the level one cycle later and `pwm_out_n` is its inverse.
- R5: If the value register is 0 or equals `RELOAD_AT`, and a tick occurs at every count, the PWM level stays 0, because a reload wins over a same-cycle match.
- R6: In mode `0100` or `1000` with run enable set, a rising edge on `cap_in` copies the current count into the value register. In the next cycle `irq` pulses and the status bit reads 1.
- R7: In mode `1000`, a tick while the count equals the value register pulses `irq` in the next cycle and clears the status bit.
- R8: With gap select `d`≠0, each output goes high only after 2^(d−1) `tick_en` cycles in which both outputs are low. The two outputs are never high together.
- R9: Writes to the status bit are ignored. Reserved bits (control 0 bits 6:4, control 1 bits 5:3) read back as written.
- R10: A capture wins over a same-cycle reload (status reads 1) and over a same-cycle write to address 1 (the value becomes the count).
- R11: With run enable clear, the count holds and neither `cap_in` nor `tick_en` produces `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer clock enable, one count step per high cycle |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| cap_in | input | 1 | Capture pin, rising edge is the event |
| pwm_out | output | 1 | Primary PWM output |
| pwm_out_n | output | 1 | Complementary PWM output |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that `cap_in` is already synchronous to `clk` and that every write strobe lasts exactly one cycle. They also assume the period parameter is at least 2, so the count is never stuck at one value. The bench drives all inputs on the falling edge. It keeps each bus write to a single cycle and holds `cap_in` stable for at least two cycles between edges, so every edge is seen once. The deliberate same-cycle collisions (capture with reload, capture with a low-byte write) are scheduled from the reference model's count, so they land on the exact cycle the requirement names.

// File: rtl/pct_pkg.sv
`timescale 1ns/1ps
package pct_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;
    localparam int DB_W   = 3;

    localparam logic [ADDR_W-1:0] ADDR_VAL_HI = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_VAL_LO = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CTL0   = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_CTL1   = 2'd3;

    localparam logic [3:0] MODE_PWM     = 4'b0011;
    localparam logic [3:0] MODE_CAPTURE = 4'b0100;
    localparam logic [3:0] MODE_CAPCMP  = 4'b1000;

    typedef enum logic [1:0] {
        ST_CMP_ON   = 2'd0,
        ST_GAP_RISE = 2'd1,
        ST_PRI_ON   = 2'd2,
        ST_GAP_FALL = 2'd3
    } db_state_e;
endpackage

// File: rtl/pct_regs.sv
`timescale 1ns/1ps
module pct_regs
    import pct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   rdata,
    input  logic                cap_evt,
    input  logic                plain_evt,
    input  logic [CNT_W-1:0]    cap_value,
    output logic [CNT_W-1:0]    val,
    output logic [3:0]          mode,
    output logic                run_en,
    output logic                pol,
    output logic [DB_W-1:0]     db_sel
);
    localparam int HALF = CNT_W / 2;

    logic [HALF-1:0]   stage_q;
    logic [CNT_W-1:0]  val_q;
    logic [BYTE_W-2:0] ctl0_q;   // control 0 bits 7:1
    logic [BYTE_W-1:0] ctl1_q;
    logic              status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            ctl0_q  <= '0;
            ctl1_q  <= '0;
        end else if (wr_en) begin
            unique case (addr)
                ADDR_VAL_HI: stage_q <= wdata;
                ADDR_CTL0:   ctl0_q  <= wdata[BYTE_W-1:1];
                ADDR_CTL1:   ctl1_q  <= wdata;
                default:     ;
            endcase
        end
    end

    // capture outranks a committing low-byte write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            val_q <= '0;
        else if (cap_evt)
            val_q <= cap_value;
        else if (wr_en && addr == ADDR_VAL_LO)
            val_q <= {stage_q, wdata};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            status_q <= 1'b0;
        else if (cap_evt)
            status_q <= 1'b1;
        else if (plain_evt)
            status_q <= 1'b0;
    end

    always_comb begin
        unique case (addr)
            ADDR_VAL_HI: rdata = val_q[CNT_W-1:HALF];
            ADDR_VAL_LO: rdata = val_q[HALF-1:0];
            ADDR_CTL0:   rdata = {ctl0_q, status_q};
            default:     rdata = ctl1_q;
        endcase
    end

    assign val    = val_q;
    assign mode   = {ctl0_q[BYTE_W-2], ctl1_q[2:0]};
    assign run_en = ctl1_q[BYTE_W-1];
    assign pol    = ctl1_q[BYTE_W-2];
    assign db_sel = ctl0_q[DB_W-1:0];

    a_r3_stage_holds_value: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_VAL_HI && !cap_evt) |=> $stable(val_q));

    a_r9_status_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_CTL0 && !cap_evt && !plain_evt) |=> $stable(status_q));

    a_r6_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (val_q == $past(cap_value)) && status_q);

    a_r7_plain_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_evt && !cap_evt) |=> !status_q);
endmodule

// File: rtl/pct_counter.sv
`timescale 1ns/1ps
module pct_counter
    import pct_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int RELOAD_AT = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cap_in,
    input  logic             run_en,
    input  logic [3:0]       mode,
    input  logic [CNT_W-1:0] val,
    output logic             cap_evt,
    output logic             plain_evt,
    output logic [CNT_W-1:0] count,
    output logic             phase,
    output logic             irq
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(RELOAD_AT);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             phase_q, cap_q, irq_q;
    logic             run_tick, at_top, hit, reload_evt, match_evt;
    logic             is_pwm, is_cap, is_capcmp;

    assign is_pwm    = (mode == MODE_PWM);
    assign is_capcmp = (mode == MODE_CAPCMP);
    assign is_cap    = (mode == MODE_CAPTURE) || is_capcmp;

    assign run_tick   = run_en & tick_en;
    assign at_top     = (cnt_q == TOP);
    assign hit        = (cnt_q == val);
    assign reload_evt = run_tick & at_top;
    assign match_evt  = is_capcmp & run_tick & hit;
    assign plain_evt  = reload_evt | match_evt;
    assign cap_evt    = run_en & is_cap & cap_in & ~cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= ONE;
        else if (run_tick)
            cnt_q <= at_top ? ONE : cnt_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= 1'b0;
        else if (!is_pwm || reload_evt)
            phase_q <= 1'b0;
        else if (run_en && hit)
            phase_q <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            cap_q <= cap_in;
            irq_q <= cap_evt | plain_evt;
        end
    end

    assign count = cnt_q;
    assign phase = phase_q;
    assign irq   = irq_q;

    a_r2_wrap_to_one: assert property (@(posedge clk) disable iff (!rst_n)
        (run_tick && at_top) |=> (cnt_q == ONE));

    a_r11_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(cnt_q));

    a_r6_irq_follows_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> irq_q);

    a_r5_reload_clears_phase: assert property (@(posedge clk) disable iff (!rst_n)
        reload_evt |=> !phase_q);
endmodule

// File: rtl/pct_deadband.sv
`timescale 1ns/1ps
module pct_deadband
    import pct_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            level,
    input  logic [DB_W-1:0] db_sel,
    output logic            pri_out,
    output logic            cmp_out
);
    localparam int GAP_W = (1 << DB_W) - 1;

    db_state_e        state_q, state_d;
    logic [GAP_W-1:0] gap_q, gap_d, gap_len;
    logic             no_gap;

    assign no_gap = (db_sel == '0);

    always_comb begin
        if (no_gap)
            gap_len = '0;
        else
            gap_len = GAP_W'(1) << (db_sel - DB_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CMP_ON;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
        end
    end

    always_comb begin
        state_d = state_q;
        gap_d   = gap_q;
        unique case (state_q)
            ST_CMP_ON: begin
                if (level) begin
                    if (no_gap) state_d = ST_PRI_ON;
                    else begin state_d = ST_GAP_RISE; gap_d = gap_len; end
                end
            end
            ST_GAP_RISE: begin
                if (!level) begin
                    if (no_gap) state_d = ST_CMP_ON;
                    else begin state_d = ST_GAP_FALL; gap_d = gap_len; end
                end else if (tick_en) begin
                    if (gap_q <= GAP_W'(1)) state_d = ST_PRI_ON;
                    else gap_d = gap_q - GAP_W'(1);
                end
            end
            ST_PRI_ON: begin
                if (!level) begin
                    if (no_gap) state_d = ST_CMP_ON;
                    else begin state_d = ST_GAP_FALL; gap_d = gap_len; end
                end
            end
            ST_GAP_FALL: begin
                if (level) begin
                    if (no_gap) state_d = ST_PRI_ON;
                    else begin state_d = ST_GAP_RISE; gap_d = gap_len; end
                end else if (tick_en) begin
                    if (gap_q <= GAP_W'(1)) state_d = ST_CMP_ON;
                    else gap_d = gap_q - GAP_W'(1);
                end
            end
        endcase
    end

    always_comb begin
        pri_out = (state_q == ST_PRI_ON);
        cmp_out = (state_q == ST_CMP_ON);
    end

    a_r8_rise_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pri_out) |-> $past(level));

    a_r8_gap_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(level) && !no_gap) |=> !pri_out && !cmp_out);

    a_r8_comp_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_out) |-> !$past(level));
endmodule

// File: rtl/pwm_capture_timer.sv
`timescale 1ns/1ps
module pwm_capture_timer
    import pct_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int RELOAD_AT = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              cap_in,
    output logic              pwm_out,
    output logic              pwm_out_n,
    output logic              irq
);
    logic [CNT_W-1:0] val, count;
    logic [3:0]       mode;
    logic [DB_W-1:0]  db_sel;
    logic             run_en, pol, cap_evt, plain_evt, phase;

    pct_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .cap_evt(cap_evt),
        .plain_evt(plain_evt), .cap_value(count), .val(val), .mode(mode),
        .run_en(run_en), .pol(pol), .db_sel(db_sel)
    );

    pct_counter #(.CNT_W(CNT_W), .RELOAD_AT(RELOAD_AT)) u_counter (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cap_in(cap_in),
        .run_en(run_en), .mode(mode), .val(val), .cap_evt(cap_evt),
        .plain_evt(plain_evt), .count(count), .phase(phase), .irq(irq)
    );

    pct_deadband u_deadband (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .level(phase ^ pol),
        .db_sel(db_sel), .pri_out(pwm_out), .cmp_out(pwm_out_n)
    );
endmodule

// File: tb/pwm_capture_timer_bench.sv
`timescale 1ns/1ps
module pwm_capture_timer_bench;
    localparam int RELOAD_AT = 40;

    logic       clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, reg_wr = 1'b0, cap_in = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       pwm_out, pwm_out_n, irq;

    int    vectors = 0, miscompares = 0;
    string cur_req = "R1";
    int    tick_mode = 0;
    logic [7:0] lfsr = 8'h5A;

    pwm_capture_timer #(.CNT_W(16), .RELOAD_AT(RELOAD_AT)) u_pwm_capture_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cap_in(cap_in), .pwm_out(pwm_out), .pwm_out_n(pwm_out_n), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // reference model state
    logic [15:0] m_cnt, m_val;
    logic [7:0]  m_stage, m_c1;
    logic [6:0]  m_c0;
    logic        m_stat, m_capq, m_phase, m_irq, m_tgt, m_pri, m_cmp;
    int          m_rem;

    task automatic model_step();
        logic [3:0]  md;
        logic        run, tk, top, hit, capev, plain, pwm, capm, lvl;
        logic [15:0] old_cnt;
        int          n;
        if (!rst_n) begin
            m_cnt = 16'd1; m_val = '0; m_stage = '0; m_c1 = '0; m_c0 = '0;
            m_stat = 0; m_capq = 0; m_phase = 0; m_irq = 0;
            m_tgt = 0; m_pri = 0; m_cmp = 1; m_rem = 0;
            return;
        end
        md    = {m_c0[6], m_c1[2:0]};
        run   = m_c1[7];
        pwm   = (md == 4'd3);
        capm  = (md == 4'd4) || (md == 4'd8);
        tk    = run && tick_en;
        top   = (m_cnt == 16'(RELOAD_AT));
        hit   = (m_cnt == m_val);
        capev = run && capm && cap_in && !m_capq;
        plain = (tk && top) || (md == 4'd8 && tk && hit);
        lvl   = m_phase ^ m_c1[6];
        n     = (m_c0[2:0] == 0) ? 0 : (1 << (m_c0[2:0] - 1));
        old_cnt = m_cnt;
        // output separation
        if (lvl != m_tgt) begin
            m_tgt = lvl;
            if (n == 0) begin m_pri = lvl; m_cmp = !lvl; end
            else begin m_pri = 0; m_cmp = 0; m_rem = n; end
        end else if (!m_pri && !m_cmp && tick_en) begin
            m_rem = m_rem - 1;
            if (m_rem == 0) begin m_pri = m_tgt; m_cmp = !m_tgt; end
        end
        // level
        if (!pwm || (tk && top)) m_phase = 0;
        else if (run && hit) m_phase = 1;
        if (tk) m_cnt = top ? 16'd1 : m_cnt + 16'd1;
        m_irq = capev || plain;
        if (capev) m_stat = 1; else if (plain) m_stat = 0;
        if (capev) m_val = old_cnt;
        else if (reg_wr && reg_addr == 2'd1) m_val = {m_stage, reg_wdata};
        if (reg_wr) begin
            if (reg_addr == 2'd0) m_stage = reg_wdata;
            if (reg_addr == 2'd2) m_c0 = reg_wdata[7:1];
            if (reg_addr == 2'd3) m_c1 = reg_wdata;
        end
        m_capq = cap_in;
    endtask

    task automatic check(string name, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, name, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rdata();
        case (reg_addr)
            2'd0:    return m_val[15:8];
            2'd1:    return m_val[7:0];
            2'd2:    return {m_c0, m_stat};
            default: return m_c1;
        endcase
    endfunction

    always @(posedge clk) begin
        model_step();
        #1;
        check("pwm_out", {7'd0, pwm_out}, {7'd0, m_pri});
        check("pwm_out_n", {7'd0, pwm_out_n}, {7'd0, m_cmp});
        check("irq", {7'd0, irq}, {7'd0, m_irq});
        check("reg_rdata", reg_rdata, exp_rdata());
    end

    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tick_en <= (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? lfsr[0] : 1'b0;
    end

    task automatic write_reg(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic cap_pulse();
        @(negedge clk); cap_in = 1;
        repeat (3) @(negedge clk);
        cap_in = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run(int n, logic [1:0] a);
        @(negedge clk); reg_addr = a;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1 reset state
        cur_req = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1;
        for (int a = 0; a < 4; a++) run(2, 2'(a));

        // R9 status read-only, reserved bits kept
        cur_req = "R9";
        write_reg(2'd2, 8'h7F); run(3, 2'd2);
        write_reg(2'd3, 8'h38); run(3, 2'd3);
        write_reg(2'd2, 8'h00); write_reg(2'd3, 8'h00);

        // R3 staged high byte
        cur_req = "R3";
        write_reg(2'd0, 8'h12); run(3, 2'd0); run(2, 2'd1);
        write_reg(2'd1, 8'h34); run(3, 2'd0); run(2, 2'd1);

        // R11 disabled timer
        cur_req = "R11";
        write_reg(2'd3, 8'h04); cap_pulse(); run(2 * RELOAD_AT, 2'd1);

        // R2 counting and reload interrupts
        cur_req = "R2";
        write_reg(2'd3, 8'h80); run(3 * RELOAD_AT, 2'd2);
        tick_mode = 1; run(4 * RELOAD_AT, 2'd2); tick_mode = 0;

        // R4 PWM with both polarities
        cur_req = "R4";
        write_reg(2'd0, 8'h00); write_reg(2'd1, 8'd10);
        write_reg(2'd3, 8'h83); run(3 * RELOAD_AT, 2'd3);
        write_reg(2'd3, 8'hC3); run(3 * RELOAD_AT, 2'd3);
        write_reg(2'd1, 8'd25); write_reg(2'd3, 8'h83);
        tick_mode = 1; run(4 * RELOAD_AT, 2'd0); tick_mode = 0;

        // R8 deadband gaps
        cur_req = "R8";
        for (int d = 1; d < 8; d++) begin
            write_reg(2'd2, 8'(d << 1));
            run(3 * RELOAD_AT, 2'd2);
        end
        write_reg(2'd2, 8'h04); tick_mode = 1; run(6 * RELOAD_AT, 2'd2);
        write_reg(2'd3, 8'hC3); run(4 * RELOAD_AT, 2'd2); tick_mode = 0;
        write_reg(2'd2, 8'h00); write_reg(2'd3, 8'h83);

        // R5 compare values that never switch
        cur_req = "R5";
        write_reg(2'd1, 8'd0); run(3 * RELOAD_AT, 2'd1);
        write_reg(2'd1, 8'(RELOAD_AT)); run(3 * RELOAD_AT, 2'd1);

        // R6 capture mode
        cur_req = "R6";
        write_reg(2'd3, 8'h84);
        for (int k = 0; k < 5; k++) begin
            run(7 + 3 * k, 2'd1); cap_pulse(); run(2, 2'd0); run(2, 2'd2);
        end

        // R7 capture/compare mode
        cur_req = "R7";
        write_reg(2'd2, 8'h80); write_reg(2'd3, 8'h80);
        write_reg(2'd0, 8'h00); write_reg(2'd1, 8'd17);
        run(3 * RELOAD_AT, 2'd2);
        cap_pulse(); run(RELOAD_AT, 2'd2);

        // R10 collisions
        cur_req = "R10";
        write_reg(2'd2, 8'h00); write_reg(2'd3, 8'h84); reg_addr = 2'd2;
        do @(negedge clk); while (m_cnt != 16'(RELOAD_AT));
        cap_in = 1;
        repeat (3) @(negedge clk);
        cap_in = 0;
        run(4, 2'd2); run(2, 2'd1);
        @(negedge clk);
        cap_in = 1; reg_wr = 1; reg_addr = 2'd1; reg_wdata = 8'h55;
        @(negedge clk); reg_wr = 0;
        repeat (3) @(negedge clk);
        cap_in = 0;
        run(3, 2'd1); run(2, 2'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 5);
        miscompares++;
        $display("FAIL all requirements watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule